// File: doc/BRIEF.md
# Dual Half-Bridge Gate Sequencer with Fault Supervision

This block is the synchronous controller for two independent half-bridge outputs. Each channel is commanded by an enable and a level input, and the block turns these into a high-side and a low-side gate request. It also takes six clean digital flags from external comparators and an active-low sleep input. From these it decides when the gates may be driven, when the charge pump may run, and when the active-low fault line is pulled.

The fault classes are treated differently. An overcurrent or sense-threshold trip is acted on only after it has lasted a deglitch window. It then opens every FET and holds them open for a timed retry interval, and the bridge is re-armed after that. A supply undervoltage opens the bridge and stops the charge pump without raising the fault line. A charge-pump undervoltage or a thermal warning raises the fault line and leaves the outputs live. A thermal shutdown opens the bridge, stops the pump and raises the fault line.

Two state machines do the sequencing. The wake machine has the states SLEEP, WAIT and RUN. Its transitions are: sleep-enter, from any state when the sleep input is low; wake-start, SLEEP to WAIT; and wake-done, WAIT to RUN once the wake count has elapsed. The trip machine has the states IDLE, GLITCH and RETRY. Its transitions are: trip-seen, IDLE to GLITCH; trip-drop, GLITCH to IDLE; trip-confirm, GLITCH to RETRY; retry-done, RETRY to IDLE; and trip-clear, from any state to IDLE while the wake machine is not in RUN. All timings are parameters counted in clock cycles.

Top module: `hbridge_supervisor`

## Requirements
- R1: In RUN with no fault gating, each channel follows its own commands. With enable low both gates are off. With enable high and input low only the low side is on. With enable high and input high only the high side is on.
- R2: The trip signal is the OR of the overcurrent flag and the sense trip. A trip that is high for fewer than DEGLITCH_CYC consecutive sampled cycles changes no output.
- R3: A trip sampled high on DEGLITCH_CYC consecutive edges turns every gate off and pulls fault_n low, starting from the cycle after the last of those edges. This lasts exactly RETRY_CYC cycles.
- R4: After the retry interval the gates follow the commands again and fault_n is released. If the trip is still present, another full deglitch and retry cycle follows.
- R5: The sense trip alone runs the same deglitch and retry sequence as the overcurrent flag.
- R6: While supply undervoltage is high, all gates and cp_en are off, and fault_n is not pulled by it.
- R7: While charge-pump undervoltage is high, fault_n is low and the gates still follow the commands.
- R8: While the thermal warning is high, fault_n is low and the gates still follow the commands. It is released in the cycle the warning drops.
- R9: While thermal shutdown is high, all gates and cp_en are off and fault_n is low. Operation resumes as soon as the input drops.
- R10: While sleep_n is low, all gates and cp_en are off and fault_n reads high. After sleep_n rises, the gates stay off for WAKE_CYC cycles.
- R11: A synchronous reset enters WAIT with cleared timers. The gates are off and fault_n is high until WAKE_CYC cycles after reset release.
- R12: The high-side and low-side gates of one channel are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_n | input | 1 | Low requests sleep |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_in | input | NUM_CH | Per-channel level command |
| oc_flag | input | 1 | Overcurrent comparator flag |
| sense_trip | input | 1 | Sense-threshold comparator flag |
| vsup_uv | input | 1 | Supply undervoltage flag |
| cp_uv | input | 1 | Charge-pump undervoltage flag |
| therm_warn | input | 1 | Thermal warning level |
| therm_shut | input | 1 | Thermal shutdown level |
| hs_on | output | NUM_CH | High-side gate request per channel |
| ls_on | output | NUM_CH | Low-side gate request per channel |
| cp_en | output | 1 | Charge-pump enable |
| fault_n | output | 1 | Fault flag, active low |

## Verification
The bench builds the block with DEGLITCH_CYC of 4, RETRY_CYC of 20 and WAKE_CYC of 10 in place of the multi-thousand-cycle defaults. With these values a persistent trip runs through several complete confirm and retry rounds in about a hundred cycles. A three-cycle pulse sits just under the deglitch limit, and a sleep, wake and reset sequence finishes in a few dozen cycles. Every requirement is therefore reached, including the edge of each window.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    typedef enum logic [1:0] {
        WAKE_SLEEP = 2'd0,
        WAKE_WAIT  = 2'd1,
        WAKE_RUN   = 2'd2
    } wake_e;

    typedef enum logic [1:0] {
        TRIP_IDLE   = 2'd0,
        TRIP_GLITCH = 2'd1,
        TRIP_RETRY  = 2'd2
    } trip_e;
endpackage

// File: rtl/hbs_wake.sv
module hbs_wake
    import hbs_pkg::*;
#(
    parameter int WAKE_CYC = 100000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep_n,
    output wake_e state
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    wake_e         nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WAKE_WAIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (!sleep_n) begin
            nxt     = WAKE_SLEEP;        // sleep-enter
            cnt_nxt = '0;
        end else begin
            unique case (state)
                WAKE_SLEEP: begin
                    nxt     = WAKE_WAIT; // wake-start
                    cnt_nxt = '0;
                end
                WAKE_WAIT: begin
                    if (cnt == CW'(WAKE_CYC - 1)) begin
                        nxt     = WAKE_RUN; // wake-done
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                WAKE_RUN: nxt = WAKE_RUN;
                default: begin
                    nxt     = WAKE_WAIT;
                    cnt_nxt = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/hbs_trip.sv
module hbs_trip
    import hbs_pkg::*;
#(
    parameter int DEGLITCH_CYC = 300,
    parameter int RETRY_CYC    = 160000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  trip,
    output trip_e state
);
    localparam int MAXC = (DEGLITCH_CYC > RETRY_CYC) ? DEGLITCH_CYC : RETRY_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    trip_e         nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TRIP_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (!active) begin
            nxt     = TRIP_IDLE;             // trip-clear
            cnt_nxt = '0;
        end else begin
            unique case (state)
                TRIP_IDLE: begin
                    if (trip) begin
                        nxt     = TRIP_GLITCH; // trip-seen
                        cnt_nxt = CW'(1);
                    end
                end
                TRIP_GLITCH: begin
                    if (!trip) begin
                        nxt     = TRIP_IDLE;   // trip-drop
                        cnt_nxt = '0;
                    end else if (cnt == CW'(DEGLITCH_CYC - 1)) begin
                        nxt     = TRIP_RETRY;  // trip-confirm
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                TRIP_RETRY: begin
                    if (cnt == CW'(RETRY_CYC - 1)) begin
                        nxt     = TRIP_IDLE;   // retry-done
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                default: begin
                    nxt     = TRIP_IDLE;
                    cnt_nxt = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/hbs_gate.sv
module hbs_gate #(
    parameter int NUM_CH = 2
) (
    input  logic              allow,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_in,
    output logic [NUM_CH-1:0] hs_on,
    output logic [NUM_CH-1:0] ls_on
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_comb begin
            hs_on[g] = 1'b0;
            ls_on[g] = 1'b0;
            if (allow && ch_en[g]) begin
                if (ch_in[g]) hs_on[g] = 1'b1;
                else          ls_on[g] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hbridge_supervisor.sv
module hbridge_supervisor
    import hbs_pkg::*;
#(
    parameter int NUM_CH       = 2,
    parameter int DEGLITCH_CYC = 300,
    parameter int RETRY_CYC    = 160000,
    parameter int WAKE_CYC     = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_n,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_in,
    input  logic              oc_flag,
    input  logic              sense_trip,
    input  logic              vsup_uv,
    input  logic              cp_uv,
    input  logic              therm_warn,
    input  logic              therm_shut,
    output logic [NUM_CH-1:0] hs_on,
    output logic [NUM_CH-1:0] ls_on,
    output logic              cp_en,
    output logic              fault_n
);
    wake_e wake_st;
    trip_e trip_st;
    logic  allow;

    hbs_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .sleep_n (sleep_n),
        .state   (wake_st)
    );

    hbs_trip #(.DEGLITCH_CYC(DEGLITCH_CYC), .RETRY_CYC(RETRY_CYC)) u_trip (
        .clk    (clk),
        .rst    (rst),
        .active (wake_st == WAKE_RUN),
        .trip   (oc_flag | sense_trip),
        .state  (trip_st)
    );

    always_comb begin
        allow   = sleep_n && (wake_st == WAKE_RUN) && (trip_st != TRIP_RETRY)
                  && !vsup_uv && !therm_shut;
        cp_en   = sleep_n && !vsup_uv && !therm_shut;
        fault_n = !sleep_n ? 1'b1
                : !((trip_st == TRIP_RETRY) || cp_uv || therm_warn || therm_shut);
    end

    hbs_gate #(.NUM_CH(NUM_CH)) u_gate (
        .allow (allow),
        .ch_en (ch_en),
        .ch_in (ch_in),
        .hs_on (hs_on),
        .ls_on (ls_on)
    );
endmodule

// File: rtl/hbs_checks.sv
module hbs_checks #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_n,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_in,
    input logic              vsup_uv,
    input logic              cp_uv,
    input logic              therm_warn,
    input logic              therm_shut,
    input logic [NUM_CH-1:0] hs_on,
    input logic [NUM_CH-1:0] ls_on,
    input logic              cp_en,
    input logic              fault_n
);
    assert_no_shoot_through_R12: assert property (@(posedge clk) disable iff (rst)
        (hs_on & ls_on) == '0);

    assert_gate_follows_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        ((hs_on & ~(ch_en & ch_in)) == '0) && ((ls_on & ~(ch_en & ~ch_in)) == '0));

    assert_uv_silent_off_R6: assert property (@(posedge clk) disable iff (rst)
        vsup_uv |-> (hs_on == '0) && (ls_on == '0) && !cp_en);

    assert_cpuv_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (cp_uv && sleep_n) |-> !fault_n);

    assert_warn_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (therm_warn && sleep_n) |-> !fault_n);

    assert_shut_off_R9: assert property (@(posedge clk) disable iff (rst)
        therm_shut |-> (hs_on == '0) && (ls_on == '0) && !cp_en);

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |-> (hs_on == '0) && (ls_on == '0) && !cp_en && fault_n);

    assert_wake_holds_off_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_n) |=> (hs_on == '0) && (ls_on == '0));
endmodule

bind hbridge_supervisor hbs_checks #(.NUM_CH(NUM_CH)) u_hbs_checks (
    .clk        (clk),
    .rst        (rst),
    .sleep_n    (sleep_n),
    .ch_en      (ch_en),
    .ch_in      (ch_in),
    .vsup_uv    (vsup_uv),
    .cp_uv      (cp_uv),
    .therm_warn (therm_warn),
    .therm_shut (therm_shut),
    .hs_on      (hs_on),
    .ls_on      (ls_on),
    .cp_en      (cp_en),
    .fault_n    (fault_n)
);

// File: tb/test_hbridge_supervisor.sv
module test_hbridge_supervisor;
    localparam int NCH = 2;
    localparam int DEG = 4;
    localparam int RTY = 20;
    localparam int WK  = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sleep_n = 1'b1;
    logic [NCH-1:0] ch_en = '0, ch_in = '0;
    logic           oc_flag = 0, sense_trip = 0, vsup_uv = 0, cp_uv = 0;
    logic           therm_warn = 0, therm_shut = 0;
    logic [NCH-1:0] hs_on, ls_on;
    logic           cp_en, fault_n;

    int    checks = 0, fails = 0;
    string tag = "R11";
    bit    started = 0;

    // behavioural model state
    int m_wake;       // 0 asleep, 1 waiting, 2 running
    int m_wait_done;  // cycles spent waiting
    int m_streak;     // consecutive trip samples
    int m_hold;       // retry cycles left

    always #5 clk = ~clk;

    hbridge_supervisor #(.NUM_CH(NCH), .DEGLITCH_CYC(DEG), .RETRY_CYC(RTY),
                         .WAKE_CYC(WK)) i_hbridge_supervisor (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .ch_en(ch_en), .ch_in(ch_in),
        .oc_flag(oc_flag), .sense_trip(sense_trip), .vsup_uv(vsup_uv),
        .cp_uv(cp_uv), .therm_warn(therm_warn), .therm_shut(therm_shut),
        .hs_on(hs_on), .ls_on(ls_on), .cp_en(cp_en), .fault_n(fault_n)
    );

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_wake = 1; m_wait_done = 0; m_streak = 0; m_hold = 0;
        end else begin
            if (m_wake != 2 || !sleep_n) begin
                m_streak = 0; m_hold = 0;
            end else if (m_hold > 0) begin
                m_hold = m_hold - 1;
            end else if (oc_flag || sense_trip) begin
                m_streak = m_streak + 1;
                if (m_streak == DEG) begin
                    m_hold = RTY; m_streak = 0;
                end
            end else begin
                m_streak = 0;
            end
            if (!sleep_n) begin
                m_wake = 0; m_wait_done = 0;
            end else if (m_wake == 0) begin
                m_wake = 1; m_wait_done = 0;
            end else if (m_wake == 1) begin
                m_wait_done = m_wait_done + 1;
                if (m_wait_done == WK) m_wake = 2;
            end
        end
    end

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic [NCH-1:0] e_hs, e_ls;
            bit live, e_cp, e_flt;
            live = sleep_n && m_wake == 2 && m_hold == 0 && !vsup_uv && !therm_shut;
            for (int c = 0; c < NCH; c++) begin
                e_hs[c] = live && ch_en[c] && ch_in[c];
                e_ls[c] = live && ch_en[c] && !ch_in[c];
            end
            e_cp  = sleep_n && !vsup_uv && !therm_shut;
            e_flt = !sleep_n || !(m_hold > 0 || cp_uv || therm_warn || therm_shut);
            check("hs_on", 32'(hs_on), 32'(e_hs));
            check("ls_on", 32'(ls_on), 32'(e_ls));
            check("cp_en", 32'(cp_en), 32'(e_cp));
            check("fault_n", 32'(fault_n), 32'(e_flt));
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
        #1;
    endtask

    task automatic run_all();
        tag = "R11";
        step(3);
        rst = 0;
        ch_en = 2'b11; ch_in = 2'b01;
        step(WK + 2);
        tag = "R1";
        for (int v = 0; v < 16; v++) begin
            ch_en = v[1:0]; ch_in = v[3:2];
            step(2);
        end
        ch_en = 2'b11; ch_in = 2'b10;
        tag = "R2";
        oc_flag = 1; step(DEG - 1); oc_flag = 0; step(5);
        sense_trip = 1; step(DEG - 1); sense_trip = 0; step(5);
        tag = "R3";
        oc_flag = 1; step(DEG + 5);
        tag = "R4";
        step(2 * (DEG + RTY));
        oc_flag = 0; step(RTY + 5);
        tag = "R5";
        sense_trip = 1; step(DEG + RTY + 3); sense_trip = 0; step(RTY + 5);
        tag = "R6";
        vsup_uv = 1; step(6); vsup_uv = 0; step(3);
        tag = "R7";
        cp_uv = 1; step(6); cp_uv = 0; step(3);
        tag = "R8";
        therm_warn = 1; step(6); therm_warn = 0; step(3);
        tag = "R9";
        therm_shut = 1; step(6); therm_shut = 0; step(3);
        tag = "R10";
        sleep_n = 0; cp_uv = 1; step(6); cp_uv = 0;
        sleep_n = 1; oc_flag = 1; step(3); oc_flag = 0;
        step(WK + 5);
        tag = "R12";
        ch_en = 2'b11; ch_in = 2'b01; step(3);
        tag = "R11";
        rst = 1; step(2); rst = 0; step(WK + 4);
    endtask

    initial begin
        bit wd = 0;
        fork
            run_all();
            begin #200000; wd = 1; end
        join_any
        disable fork;
        if (wd) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule